// File: doc/BRIEF.md
# Near Branch and Loop Decision Unit

This unit settles, for one near relative control transfer at a time, whether the transfer is taken, what the following instruction pointer is, and what the count register holds afterwards. Each request carries a branch kind, a 4-bit condition code, the current flags word, the count register value, the current instruction pointer and an 8-bit signed displacement. A branch kind is one of four: conditional, unconditional, loop with decrement, or jump when the count is zero.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream after one register stage. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its content is being taken by the consumer in the same cycle, so one result per cycle flows under no back-pressure. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. A producer may hold or drop `in_valid` freely.

Top module: `brx_decide`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0.
- R2: Flags word bit positions are carry 0, parity 2, zero 6, sign 7, overflow 11. For a conditional kind (`in_kind`=0), codes 12..15 are the signed set: 12 taken when sign xor overflow is 1, 13 its inverse; 14 taken when (sign xor overflow) or zero is 1, 15 its inverse.
- R3: Conditional codes 2..7: 2 taken when carry is 1, 3 its inverse; 4 taken when zero is 1, 5 its inverse; 6 taken when carry or zero is 1, 7 its inverse.
- R4: Conditional codes 0, 1 and 8..11 test a single flag: 0 overflow=1, 1 overflow=0, 8 sign=1, 9 sign=0, 10 parity=1, 11 parity=0.
- R5: Kind 1 (unconditional) is always taken, whatever the flags and condition code.
- R6: Kind 2 (loop) reports the count minus one modulo 2^16 and is taken when that new count is nonzero; a count of 0 becomes 0xFFFF and is taken, a count of 1 becomes 0 and falls through.
- R7: Kind 3 is taken exactly when the count is 0; kinds 0, 1 and 3 report the count unchanged.
- R8: When taken, the next pointer is the current pointer plus the sign-extended displacement modulo 2^16; when not taken it equals the current pointer.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`; an accepted request appears on the output on the next cycle, and a stalled result stays unchanged until consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_kind | input | 2 | 0 conditional, 1 unconditional, 2 loop, 3 jump on count zero |
| in_cond | input | 4 | Condition code, low bit selects the inverted form |
| in_flags | input | 16 | Flags word |
| in_count | input | 16 | Count register value |
| in_ip | input | 16 | Pointer past the branch instruction |
| in_disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_taken | output | 1 | Transfer is taken |
| out_next_ip | output | 16 | Next instruction pointer |
| out_count | output | 16 | Count register after the instruction |

## Verification
A wrong condition mapping or a swapped polarity bit shows up as a wrong `out_taken` one cycle after the request is accepted, and drags `out_next_ip` with it. A faulty decrement or zero test corrupts `out_count` or the taken decision on the very next result, and the count wrap case exposes borrow errors. A broken hold or ready path shows as a changed result or a lost request during the first stalled cycle.

// File: rtl/brx_pkg.sv
`timescale 1ns/1ps
package brx_pkg;
  localparam int IP_W   = 16;
  localparam int CNT_W  = 16;
  localparam int DISP_W = 8;
  localparam int FLG_W  = 16;
  localparam int CC_W   = 4;

  localparam int FB_CARRY  = 0;
  localparam int FB_PARITY = 2;
  localparam int FB_ZERO   = 6;
  localparam int FB_SIGN   = 7;
  localparam int FB_OVFL   = 11;

  typedef enum logic [1:0] {
    K_COND = 2'd0,
    K_JUMP = 2'd1,
    K_LOOP = 2'd2,
    K_CXZ  = 2'd3
  } kind_e;
endpackage

// File: rtl/brx_cond_eval.sv
`timescale 1ns/1ps
module brx_cond_eval
  import brx_pkg::*;
#(
  parameter int CW = CC_W
) (
  input  logic          f_carry,
  input  logic          f_parity,
  input  logic          f_zero,
  input  logic          f_sign,
  input  logic          f_ovfl,
  input  logic [CW-1:0] cond,
  output logic          hit
);
  localparam int PAIRS = 1 << (CW - 1);

  logic [PAIRS-1:0] base;
  logic             lt;

  assign lt = f_sign ^ f_ovfl;

  // Positive member of each pair; the low code bit inverts it.
  always_comb begin
    base    = '0;
    base[0] = f_ovfl;
    base[1] = f_carry;
    base[2] = f_zero;
    base[3] = f_carry | f_zero;
    base[4] = f_sign;
    base[5] = f_parity;
    base[6] = lt;
    base[7] = lt | f_zero;
  end

  assign hit = base[cond[CW-1:1]] ^ cond[0];
endmodule

// File: rtl/brx_target.sv
`timescale 1ns/1ps
module brx_target #(
  parameter int IW = 16,
  parameter int DW = 8
) (
  input  logic [IW-1:0] ip,
  input  logic [DW-1:0] disp,
  input  logic          taken,
  output logic [IW-1:0] next_ip
);
  localparam int EXT = IW - DW;

  logic [IW-1:0] disp_x;
  logic [IW-1:0] dest;

  generate
    if (EXT > 0) begin : g_ext
      assign disp_x = {{EXT{disp[DW-1]}}, disp};
    end else begin : g_same
      assign disp_x = disp[IW-1:0];
    end
  endgenerate

  assign dest    = ip + disp_x;
  assign next_ip = taken ? dest : ip;
endmodule

// File: rtl/brx_counter.sv
`timescale 1ns/1ps
module brx_counter
  import brx_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  kind_e         kind,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next,
  output logic          zero_now,
  output logic          live_after
);
  logic [CW-1:0] dec;

  assign dec        = cnt - CW'(1);
  assign zero_now   = (cnt == '0);
  assign live_after = (dec != '0);
  assign cnt_next   = (kind == K_LOOP) ? dec : cnt;
endmodule

// File: rtl/brx_decide.sv
`timescale 1ns/1ps
module brx_decide
  import brx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [CC_W-1:0]   in_cond,
  input  logic [FLG_W-1:0]  in_flags,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [IP_W-1:0]   in_ip,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [IP_W-1:0]   out_next_ip,
  output logic [CNT_W-1:0]  out_count
);
  kind_e             kind;
  logic              cond_hit, zero_now, live_after, taken;
  logic [CNT_W-1:0]  cnt_next;
  logic [IP_W-1:0]   nip;
  logic              load;
  kind_e             r_kind;

  assign kind = kind_e'(in_kind);

  brx_cond_eval #(.CW(CC_W)) u_cond (
    .f_carry (in_flags[FB_CARRY]),
    .f_parity(in_flags[FB_PARITY]),
    .f_zero  (in_flags[FB_ZERO]),
    .f_sign  (in_flags[FB_SIGN]),
    .f_ovfl  (in_flags[FB_OVFL]),
    .cond    (in_cond),
    .hit     (cond_hit)
  );

  brx_counter #(.CW(CNT_W)) u_cnt (
    .kind      (kind),
    .cnt       (in_count),
    .cnt_next  (cnt_next),
    .zero_now  (zero_now),
    .live_after(live_after)
  );

  always_comb begin
    unique case (kind)
      K_COND:  taken = cond_hit;
      K_JUMP:  taken = 1'b1;
      K_LOOP:  taken = live_after;
      default: taken = zero_now;
    endcase
  end

  brx_target #(.IW(IP_W), .DW(DISP_W)) u_tgt (
    .ip     (in_ip),
    .disp   (in_disp),
    .taken  (taken),
    .next_ip(nip)
  );

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_taken   <= taken;
      out_next_ip <= nip;
      out_count   <= cnt_next;
      r_kind      <= kind;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taken)
      && $stable(out_next_ip) && $stable(out_count)));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_kind == K_JUMP) |-> out_taken);

  assert_loop_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_kind == K_LOOP) |-> (out_taken == (out_count != '0)));

  assert_cxz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_kind == K_CXZ) |-> (out_taken == (out_count == '0)));
endmodule

// File: tb/brx_decide_tb.sv
`timescale 1ns/1ps
module brx_decide_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_taken;
  logic [1:0]  in_kind = '0;
  logic [3:0]  in_cond = '0;
  logic [15:0] in_flags = '0, in_count = '0, in_ip = '0;
  logic [7:0]  in_disp = '0;
  logic [15:0] out_next_ip, out_count;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state of the output register
  logic        m_valid = 0, m_taken = 0;
  logic [15:0] m_ip = 0, m_cnt = 0;
  string       m_tag = "R9";

  always #2.5 clk = ~clk;

  brx_decide u_dut (.*);

  function automatic bit ref_taken(input logic [1:0] k, input logic [3:0] c,
                                   input logic [15:0] f, input logic [15:0] cx);
    bit cf = f[0], pf = f[2], zf = f[6], sf = f[7], of_ = f[11];
    case (k)
      2'd1: return 1;
      2'd2: return ((cx + 16'hFFFF) & 16'hFFFF) != 0;
      2'd3: return cx == 0;
      default: case (c)
        4'd0:  return of_;
        4'd1:  return !of_;
        4'd2:  return cf;
        4'd3:  return !cf;
        4'd4:  return zf;
        4'd5:  return !zf;
        4'd6:  return cf || zf;
        4'd7:  return !cf && !zf;
        4'd8:  return sf;
        4'd9:  return !sf;
        4'd10: return pf;
        4'd11: return !pf;
        4'd12: return sf != of_;
        4'd13: return sf == of_;
        4'd14: return (sf != of_) || zf;
        default: return (sf == of_) && !zf;
      endcase
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic [3:0] c);
    if (k == 2'd1) return "R5";
    if (k == 2'd2) return "R6";
    if (k == 2'd3) return "R7";
    if (c >= 4'd12) return "R2";
    if (c >= 4'd2 && c <= 4'd7) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_out();
    chk("R9 out_valid", 16'(out_valid), 16'(m_valid));
    if (m_valid) begin
      chk({m_tag, " taken"}, 16'(out_taken), 16'(m_taken));
      chk("R8 next_ip", out_next_ip, m_ip);
      chk({m_tag == "R6" ? "R6" : "R7", " count"}, out_count, m_cnt);
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic step(input logic v, input logic rdy, input logic [1:0] k,
                      input logic [3:0] c, input logic [15:0] f,
                      input logic [15:0] cx, input logic [15:0] ip,
                      input logic [7:0] d);
    bit t;
    compare_out();
    in_valid = v; out_ready = rdy; in_kind = k; in_cond = c;
    in_flags = f; in_count = cx; in_ip = ip; in_disp = d;
    #1;
    chk("R9 in_ready", 16'(in_ready), 16'(!m_valid || rdy));
    @(posedge clk);
    if (!m_valid || rdy) begin
      m_valid = v;
      if (v) begin
        t       = ref_taken(k, c, f, cx);
        m_taken = t;
        m_ip    = t ? 16'(int'(ip) + int'($signed(d))) : ip;
        m_cnt   = (k == 2'd2) ? 16'(cx - 16'd1) : cx;
        m_tag   = tag_of(k, c);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) begin
      chk("R1 reset valid", 16'(out_valid), 16'h0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    chk("R1 after reset", 16'(out_valid), 16'h0);
    // R2 signed set: sign=1 overflow=0 -> less
    step(1, 1, 2'd0, 4'd12, 16'h0080, 16'd5, 16'h1000, 8'h10);
    step(1, 1, 2'd0, 4'd13, 16'h0880, 16'd5, 16'h1000, 8'h10);
    step(1, 1, 2'd0, 4'd15, 16'h0040, 16'd5, 16'h1000, 8'hF0);
    step(1, 1, 2'd0, 4'd14, 16'h0040, 16'd5, 16'h1000, 8'hF0);
    // R3 unsigned and equality
    step(1, 1, 2'd0, 4'd7, 16'h0000, 16'd5, 16'h2000, 8'h7F);
    step(1, 1, 2'd0, 4'd6, 16'h0001, 16'd5, 16'h2000, 8'h80);
    step(1, 1, 2'd0, 4'd5, 16'h0040, 16'd5, 16'h2000, 8'h01);
    // R4 single flag tests
    step(1, 1, 2'd0, 4'd10, 16'h0004, 16'd5, 16'h3000, 8'h02);
    step(1, 1, 2'd0, 4'd1, 16'h0800, 16'd5, 16'h3000, 8'h02);
    // R5 unconditional, R8 wrap forward past 0xFFFF
    step(1, 1, 2'd1, 4'd0, 16'h0000, 16'd5, 16'hFFF0, 8'h20);
    // R6 loop corner counts: 1 falls through, 0 wraps and is taken
    step(1, 1, 2'd2, 4'd0, 16'h0000, 16'd1, 16'h0010, 8'hFE);
    step(1, 1, 2'd2, 4'd0, 16'h0000, 16'd0, 16'h0010, 8'hFE);
    step(1, 1, 2'd2, 4'd0, 16'h0000, 16'd9, 16'h0005, 8'h80);
    // R7 count-zero test
    step(1, 1, 2'd3, 4'd0, 16'hFFFF, 16'd0, 16'h4000, 8'h04);
    step(1, 1, 2'd3, 4'd0, 16'hFFFF, 16'd2, 16'h4000, 8'h04);
    // R9 stall: result must hold, request must wait
    step(1, 0, 2'd1, 4'd0, 16'h0000, 16'd3, 16'h5000, 8'h08);
    step(1, 0, 2'd0, 4'd4, 16'h0040, 16'd3, 16'h6000, 8'h08);
    step(1, 0, 2'd0, 4'd4, 16'h0040, 16'd3, 16'h6000, 8'h08);
    step(1, 1, 2'd0, 4'd4, 16'h0040, 16'd3, 16'h6000, 8'h08);
    step(0, 1, 2'd0, 4'd0, 16'h0000, 16'd0, 16'h0000, 8'h00);
    // mixed traffic with random back-pressure, all kinds R2..R9
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] cx = ($urandom % 4 == 0) ? 16'($urandom % 3) : 16'($urandom);
      step(1'($urandom % 4 != 0), 1'($urandom % 3 != 0), 2'($urandom),
           4'($urandom), 16'($urandom), cx, 16'($urandom), 8'($urandom));
    end
    step(0, 1, 2'd0, 4'd0, 16'h0, 16'h0, 16'h0, 8'h0);
    compare_out();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule